// File: doc/BRIEF.md
# Programmable Prescaled Interval Timer

This block is a synchronous interval timer with one system clock. An external timer input is brought into the clock domain and then watched for rising and falling edges. When an edge that the current mode accepts shows up, an 8-bit down-counter is loaded from a parallel preset bus. The output goes high at the same moment and stays high while the loaded interval runs. The counter steps once per prescaler tick. The prescaler passes the clock through undivided or divides it by one of three powers of two, chosen by a 2-bit code.

A 3-bit mode code selects how the timer reacts to edges. In counter mode only a falling edge starts an interval, and edges that arrive while an interval is running are ignored. If the output is wired back to the timer input, the timer then runs freely: each end of an interval produces the falling edge that starts the next one. The three one-shot modes react to the rising edge, the falling edge or both edges. They are retriggerable, so a new qualifying edge reloads the counter and the interval starts over. Any other mode code holds the timer idle.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset the output `tmr_o` is low and no interval is running.
- R2: `tin_i` passes through two synchronizing flops before edge detection. When `tin_i` changes before clock edge c+1, the counter loads on edge c+3, and `tmr_o` is high from that edge on.
- R3: `div_sel_i` selects the counter step rate. 0 steps on every clock. 1, 2 and 3 step on every 2^DIV_A_LOG2-th, 2^DIV_B_LOG2-th and 2^DIV_C_LOG2-th clock respectively (16, 256 and 4096 with the default parameters). With a preset N and a divide factor D, `tmr_o` stays high for N*D+1 clock cycles.
- R4: A preset of 0 gives a `tmr_o` pulse exactly one clock cycle long.
- R5: Counter mode (`mode_i` = 3'b001): a falling edge of the synchronized input starts an interval. Rising edges are ignored, and so is every edge that arrives while an interval is running.
- R6: In counter mode, with `tmr_o` fed back to `tin_i`, the timer runs freely. Each pulse is N*D+1 cycles high, and consecutive rising edges of `tmr_o` are N*D+4 cycles apart.
- R7: Rising one-shot (`mode_i` = 3'b010): a rising edge loads the counter, even while an interval is running. Falling edges are ignored.
- R8: Falling one-shot (`mode_i` = 3'b011): a falling edge loads the counter, even while an interval is running. Rising edges are ignored.
- R9: Dual-edge one-shot (`mode_i` = 3'b100): both edges load the counter.
- R10: Mode codes 3'b000, 3'b101, 3'b110 and 3'b111 drive `tmr_o` low in the same cycle and drop any running interval. Returning to a valid mode does not resume that interval, and input edges seen while in these codes start nothing.
- R11: Every load restarts the prescaler phase. After the most recent load, `tmr_o` stays high for exactly N*D+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tin_i | input | 1 | Asynchronous timer input |
| preset_i | input | CNT_W | Parallel value loaded into the counter |
| div_sel_i | input | 2 | Prescale select |
| mode_i | input | 3 | Mode code |
| tmr_o | output | 1 | Timer output, high while an interval runs |

## Verification
The bench builds the timer with DIV_A_LOG2=1, DIV_B_LOG2=2 and DIV_C_LOG2=3. All four prescale settings therefore give divide factors of 1, 2, 4 and 8, and every interval fits into tens of cycles. With these settings the exact pulse-width formula can be checked at every prescale code, a retrigger can land mid-tick and test the prescaler phase restart, and three free-running periods fit in a short run.

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer #(
  parameter int CNT_W      = 8,
  parameter int DIV_A_LOG2 = 4,
  parameter int DIV_B_LOG2 = 8,
  parameter int DIV_C_LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tin_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic [1:0]       div_sel_i,
  input  logic [2:0]       mode_i,
  output logic             tmr_o
);

  localparam int PRE_W = DIV_C_LOG2;
  localparam logic [2:0] M_COUNT = 3'b001;
  localparam logic [2:0] M_RISE  = 3'b010;
  localparam logic [2:0] M_FALL  = 3'b011;
  localparam logic [2:0] M_BOTH  = 3'b100;

  logic             sync_a, sync_b, sync_d;
  logic             rise, fall, qual, mode_ok, tick;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_a <= tin_i;
      sync_b <= sync_a;
      sync_d <= sync_b;
    end
  end

  assign rise = sync_b & ~sync_d;
  assign fall = ~sync_b & sync_d;

  always_comb begin
    mode_ok = 1'b1;
    case (mode_i)
      M_COUNT: qual = fall & ~busy_q;
      M_RISE:  qual = rise;
      M_FALL:  qual = fall;
      M_BOTH:  qual = rise | fall;
      default: begin
        qual    = 1'b0;
        mode_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (div_sel_i)
      2'd0:    tick = 1'b1;
      2'd1:    tick = &pre_q[DIV_A_LOG2-1:0];
      2'd2:    tick = &pre_q[DIV_B_LOG2-1:0];
      default: tick = &pre_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (!mode_ok) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (qual) begin
      busy_q <= 1'b1;
      cnt_q  <= preset_i;
      pre_q  <= '0;
    end else if (busy_q) begin
      pre_q <= pre_q + 1'b1;
      if (cnt_q == '0)
        busy_q <= 1'b0;
      else if (tick)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tmr_o = busy_q & mode_ok;

  a_r10_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok |=> (!busy_q && cnt_q == '0));

  a_r7_load_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok && qual) |=> (busy_q && cnt_q == $past(preset_i)));

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok && busy_q && !qual && !tick && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q)));

  a_r3_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok && busy_q && !qual && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r4_release_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok && busy_q && !qual && cnt_q == '0) |=> !busy_q);

  a_r5_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_COUNT && busy_q && cnt_q != '0) |=> (busy_q && cnt_q <= $past(cnt_q)));

endmodule

// File: tb/test_prescaled_interval_timer.sv
module test_prescaled_interval_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tin_drv = 1'b0;
  logic          fb_en = 1'b0;
  logic [CW-1:0] preset = '0;
  logic [1:0]    div = 2'd0;
  logic [2:0]    mode = 3'b000;
  logic          tmr;
  logic          tin;

  assign tin = fb_en ? tmr : tin_drv;

  always #10 clk = ~clk;

  prescaled_interval_timer #(.CNT_W(CW), .DIV_A_LOG2(1), .DIV_B_LOG2(2), .DIV_C_LOG2(3))
    i_prescaled_interval_timer (
      .clk_i(clk), .rst_ni(rst_n), .tin_i(tin), .preset_i(preset),
      .div_sel_i(div), .mode_i(mode), .tmr_o(tmr));

  typedef struct { int start; int width; string req; } pulse_t;
  pulse_t expq[$];

  int    cyc = 0, checks = 0, errors = 0;
  int    rise_cyc = 0;
  bit    prev_out = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      if (rst_n) begin
        if (tmr && !prev_out) rise_cyc = cyc;
        if (!tmr && prev_out) begin
          if (expq.size() == 0) begin
            chk(1'b0, cur_req, "unexpected pulse start", rise_cyc, -1);
          end else begin
            pulse_t e;
            e = expq.pop_front();
            chk(e.start == rise_cyc, e.req, "pulse start cycle", rise_cyc, e.start);
            chk(e.width == cyc - rise_cyc, e.req, "pulse width", cyc - rise_cyc, e.width);
          end
        end
        prev_out = tmr;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_tin(bit v, output int c);
    @(negedge clk);
    tin_drv = v;
    c = cyc;
  endtask

  task automatic push(int s, int w, string r);
    pulse_t e;
    e.start = s;
    e.width = w;
    e.req = r;
    expq.push_back(e);
  endtask

  task automatic drain();
    wait (expq.size() == 0);
    step(4);
  endtask

  task automatic expect_low(string r, string what);
    chk(tmr == 1'b0, r, what, int'(tmr), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog expired, actual 0 expected 1 completion");
      summary();
    end
  end

  initial begin
    int c, c1, c2, x, m;
    step(3);
    expect_low("R1", "output during reset");
    rst_n = 1'b1;
    step(3);
    expect_low("R1", "output after reset");

    // R2 R7: rising one-shot, undivided
    cur_req = "R7";
    mode = 3'b010; div = 2'd0; preset = 8'd5;
    set_tin(1'b1, c); push(c + 3, 6, "R2"); drain();
    set_tin(1'b0, c); step(8);
    expect_low("R7", "falling edge ignored");

    // R3: every prescale code
    cur_req = "R3";
    div = 2'd1; preset = 8'd3;
    set_tin(1'b1, c); push(c + 3, 7, "R3"); drain();
    set_tin(1'b0, c); step(6);
    div = 2'd2; preset = 8'd2;
    set_tin(1'b1, c); push(c + 3, 9, "R3"); drain();
    set_tin(1'b0, c); step(6);
    div = 2'd3; preset = 8'd2;
    set_tin(1'b1, c); push(c + 3, 17, "R3"); drain();
    set_tin(1'b0, c); step(6);

    // R4: zero preset
    cur_req = "R4";
    div = 2'd3; preset = 8'd0;
    set_tin(1'b1, c); push(c + 3, 1, "R4"); drain();
    set_tin(1'b0, c); step(6);

    // R11 R7: retrigger mid-interval restarts counter and prescaler phase
    cur_req = "R11";
    div = 2'd3; preset = 8'd3;
    set_tin(1'b1, c1); step(5);
    set_tin(1'b0, x); step(7);
    set_tin(1'b1, c2);
    push(c1 + 3, (c2 - c1) + 25, "R11");
    drain();
    set_tin(1'b0, c); step(6);

    // R8: falling one-shot
    cur_req = "R8";
    mode = 3'b011; div = 2'd0; preset = 8'd4;
    set_tin(1'b1, c); step(8);
    expect_low("R8", "rising edge ignored");
    set_tin(1'b0, c); push(c + 3, 5, "R8"); drain();

    // R9: both edges
    cur_req = "R9";
    mode = 3'b100; div = 2'd1; preset = 8'd2;
    set_tin(1'b1, c); push(c + 3, 5, "R9"); drain();
    set_tin(1'b0, c); push(c + 3, 5, "R9"); drain();

    // R5: counter mode, no retrigger
    cur_req = "R5";
    mode = 3'b001; div = 2'd1; preset = 8'd6;
    set_tin(1'b1, c); step(8);
    expect_low("R5", "rising edge ignored in counter mode");
    set_tin(1'b0, c1);
    push(c1 + 3, 13, "R5");
    step(3); set_tin(1'b1, x);
    step(3); set_tin(1'b0, x);
    drain();

    // R6: free-running with output fed back
    cur_req = "R6";
    preset = 8'd2; div = 2'd1;
    set_tin(1'b1, x); step(6);
    expect_low("R6", "idle before feedback");
    @(negedge clk);
    fb_en = 1'b1;
    c = cyc;
    push(c + 3, 5, "R6");
    push(c + 11, 5, "R6");
    push(c + 19, 5, "R6");
    wait (expq.size() == 0);
    @(negedge clk);
    mode = 3'b000; fb_en = 1'b0; tin_drv = 1'b0;
    step(6);
    expect_low("R10", "free run stopped by idle code");

    // R10: idle codes
    cur_req = "R10";
    mode = 3'b010; div = 2'd3; preset = 8'd10;
    set_tin(1'b1, c); step(10);
    @(negedge clk);
    mode = 3'b101;
    m = cyc;
    push(c + 3, m + 1 - (c + 3), "R10");
    #1;
    expect_low("R10", "output low at once on code 101");
    step(3);
    mode = 3'b010;
    step(6);
    expect_low("R10", "interval not resumed");
    mode = 3'b110;
    set_tin(1'b0, x); step(4); set_tin(1'b1, x); step(6);
    expect_low("R10", "edges ignored on code 110");
    mode = 3'b111;
    set_tin(1'b0, x); step(4); set_tin(1'b1, x); step(6);
    expect_low("R10", "edges ignored on code 111");
    mode = 3'b000;
    set_tin(1'b0, x); step(4); set_tin(1'b1, x); step(6);
    expect_low("R10", "edges ignored on code 000");
    mode = 3'b010;
    step(6);
    expect_low("R10", "no late start after idle");

    step(5);
    chk(expq.size() == 0, cur_req, "expected pulses left over", expq.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule